// File: doc/BRIEF.md
# Spare Area Buffer Address Mapper

The mapper turns a linear byte offset inside a flash page's spare (out-of-band) area into addresses for a controller's chunked spare buffer RAM. A page is handled in 512-byte chunks. Each chunk owns one 64-byte spare buffer, and the valid spare bytes are divided evenly across the buffers. The per-buffer share is the spare size divided by the chunk count, with bit 0 cleared. Whatever the even split leaves over belongs to the last buffer.

Software-independent configuration arrives on a load strobe carrying the page size and spare size. A sequential divider then derives the per-buffer share, and the mapper reports configured once that is done. A transfer request carries a start offset and a byte count. The mapper locates the starting buffer, then emits one RAM address per cycle, moving to byte 0 of the next buffer whenever the current share is used up. It pulses done after the last byte. If an address would fall outside a 64-byte buffer, it flags an error and stops.

Top module: `spare_addr_mapper`

## Requirements
- R1: While reset is held and right after it is released, cfg_ready, xfer_ready, ram_addr_valid, xfer_done and xfer_err are all 0.
- R2: A cfg_load accepted while no transfer is active drops cfg_ready in the next cycle. cfg_ready rises again SPARE_W+1 cycles after the load cycle. The per-buffer share then equals floor(spare / (page / 512)) with bit 0 forced to 0.
- R3: Buffer n occupies RAM addresses 0x1000 + n*0x40 up to 0x103F + n*0x40. Every issued address is that base plus the byte position inside the buffer.
- R4: The starting buffer index is offset / share, limited to at most 7. The starting position inside that buffer is offset - index*share.
- R5: In buffers 0 to 6, the byte after position share-1 is issued at position 0 of the next buffer. All other consecutive addresses differ by exactly 1.
- R6: Buffer 7 never hands over to another buffer. Offsets beyond the even split keep counting upward inside buffer 7.
- R7: A byte whose position inside its buffer would be 64 or more is not issued. In the following cycle, xfer_done and xfer_err both assert, and no further bytes of that transfer are issued.
- R8: Call k the number of buffers skipped to reach the starting index. The first address appears k+2 cycles after the accept cycle, and later addresses follow in consecutive cycles. Without an error, xfer_done pulses in the cycle after the last address. A zero-length transfer pulses xfer_done k+2 cycles after acceptance and issues no address.
- R9: xfer_ready is 1 only when the block is configured, no transfer is active and cfg_load is low. A request presented while xfer_ready is 0 is ignored and does not change the address stream.
- R10: xfer_done is high for a single cycle per transfer, and xfer_err is only ever high together with xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load a new page/spare configuration |
| cfg_page_size | input | PAGE_W | Page size in bytes (multiple of 512) |
| cfg_spare_size | input | SPARE_W | Spare area size in bytes |
| cfg_ready | output | 1 | Per-buffer share computed and valid |
| xfer_valid | input | 1 | Transfer request |
| xfer_offset | input | OFF_W | Start offset within the spare area |
| xfer_len | input | LEN_W | Number of bytes to stream |
| xfer_ready | output | 1 | Request accepted when high together with xfer_valid |
| ram_addr_valid | output | 1 | ram_addr holds an address for this cycle |
| ram_addr | output | ADDR_W | Spare buffer RAM byte address |
| xfer_done | output | 1 | One-cycle pulse ending a transfer |
| xfer_err | output | 1 | Transfer stopped on a buffer overrun (with xfer_done) |

## Verification
Every result has a fixed cycle offset from the accept cycle. Locating the starting buffer costs k+1 cycles, so the first address is due at k+2. Each further byte is due exactly one cycle later, and the done pulse comes one cycle after the last address, or two cycles after it when an overrun ends the transfer. The bench computes k and every address from the requirement formulas alone. It samples on falling edges and counts cycles from the accept edge, so each address is compared both for value and for arrival cycle. The configuration latency of SPARE_W+1 cycles is checked the same way.

// File: rtl/spare_map_pkg.sv
package spare_map_pkg;

   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_SEEK   = 2'd1,
      WK_STREAM = 2'd2,
      WK_DONE   = 2'd3
   } walk_state_t;

endpackage

// File: rtl/spare_size_div.sv
module spare_size_div #(
   parameter int PAGE_W    = 13,
   parameter int SPARE_W   = 8,
   parameter int CHUNK_LG2 = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PAGE_W-1:0]  page_size,
   input  logic [SPARE_W-1:0] spare_size,
   output logic               ready,
   output logic [SPARE_W-1:0] per_buf
);

   localparam int CNT_W = $clog2(SPARE_W + 1);
   localparam int CMP_W = (PAGE_W > SPARE_W + 1) ? PAGE_W : SPARE_W + 1;

   logic [PAGE_W-1:0]  divisor_q;
   logic [SPARE_W-1:0] quo_q;
   logic [SPARE_W-1:0] rem_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               busy_q;
   logic               ready_q;

   logic [SPARE_W:0]   trial;
   logic               take;
   logic [PAGE_W-1:0]  chunks;

   assign chunks = page_size >> CHUNK_LG2;
   assign trial  = {rem_q, quo_q[SPARE_W-1]};
   assign take   = CMP_W'(trial) >= CMP_W'(divisor_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor_q <= '0;
         quo_q     <= '0;
         rem_q     <= '0;
         cnt_q     <= '0;
         busy_q    <= 1'b0;
         ready_q   <= 1'b0;
      end else if (load) begin
         divisor_q <= (chunks == '0) ? PAGE_W'(1) : chunks;
         quo_q     <= spare_size;
         rem_q     <= '0;
         cnt_q     <= CNT_W'(SPARE_W);
         busy_q    <= 1'b1;
         ready_q   <= 1'b0;
      end else if (busy_q) begin
         rem_q <= take ? SPARE_W'(trial - (SPARE_W + 1)'(divisor_q))
                       : SPARE_W'(trial);
         quo_q <= {quo_q[SPARE_W-2:0], take};
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b1;
         end
      end
   end

   assign ready   = ready_q;
   assign per_buf = {quo_q[SPARE_W-1:1], 1'b0};

   // R2
   cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !ready);

   // R2
   cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !ready);

endmodule

// File: rtl/spare_walk.sv
module spare_walk
   import spare_map_pkg::*;
#(
   parameter int OFF_W     = 8,
   parameter int LEN_W     = 9,
   parameter int SPARE_W   = 8,
   parameter int NUM_BUFS  = 8,
   parameter int BUF_BYTES = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [OFF_W-1:0]             offset,
   input  logic [LEN_W-1:0]             len,
   input  logic [SPARE_W-1:0]           per_buf,
   output logic                         idle,
   output logic [$clog2(NUM_BUFS)-1:0]  idx,
   output logic [$clog2(BUF_BYTES)-1:0] pos,
   output logic                         addr_valid,
   output logic                         done,
   output logic                         err
);

   localparam int IDX_W   = $clog2(NUM_BUFS);
   localparam int BUF_LG2 = $clog2(BUF_BYTES);
   localparam int CMP_W   = ((OFF_W > SPARE_W) ? OFF_W : SPARE_W) + 1;

   walk_state_t      state_q;
   logic [IDX_W-1:0] idx_q;
   logic [OFF_W-1:0] rem_q;
   logic [LEN_W-1:0] left_q;
   logic             err_q;

   logic [CMP_W-1:0] rem_x;
   logic [CMP_W-1:0] sb_x;
   logic             last_buf;
   logic             ovf;
   logic             wrap;

   assign rem_x    = CMP_W'(rem_q);
   assign sb_x     = CMP_W'(per_buf);
   assign last_buf = (idx_q == IDX_W'(NUM_BUFS - 1));
   assign ovf      = (rem_x >= CMP_W'(BUF_BYTES));
   assign wrap     = !last_buf && ((rem_x + CMP_W'(1)) == sb_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         idx_q   <= '0;
         rem_q   <= '0;
         left_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            WK_IDLE: begin
               if (start) begin
                  state_q <= WK_SEEK;
                  idx_q   <= '0;
                  rem_q   <= offset;
                  left_q  <= len;
                  err_q   <= 1'b0;
               end
            end
            WK_SEEK: begin
               if (!last_buf && (rem_x >= sb_x)) begin
                  rem_q <= rem_q - OFF_W'(sb_x);
                  idx_q <= idx_q + IDX_W'(1);
               end else begin
                  state_q <= (left_q == '0) ? WK_DONE : WK_STREAM;
               end
            end
            WK_STREAM: begin
               if (ovf) begin
                  err_q   <= 1'b1;
                  state_q <= WK_DONE;
               end else begin
                  left_q <= left_q - LEN_W'(1);
                  if (left_q == LEN_W'(1)) state_q <= WK_DONE;
                  if (wrap) begin
                     idx_q <= idx_q + IDX_W'(1);
                     rem_q <= '0;
                  end else begin
                     rem_q <= rem_q + OFF_W'(1);
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   assign idle       = (state_q == WK_IDLE);
   assign idx        = idx_q;
   assign pos        = rem_q[BUF_LG2-1:0];
   assign addr_valid = (state_q == WK_STREAM) && !ovf;
   assign done       = (state_q == WK_DONE);
   assign err        = done && err_q;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R4
   seek_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !last_buf) |-> (rem_x < sb_x));

endmodule

// File: rtl/spare_addr_form.sv
module spare_addr_form #(
   parameter int IDX_W      = 3,
   parameter int BUF_LG2    = 6,
   parameter int ADDR_W     = 13,
   parameter int SPARE_BASE = 'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BUF_LG2-1:0] pos,
   output logic [ADDR_W-1:0] addr
);

   localparam int SPAN    = (1 << (IDX_W + BUF_LG2));
   localparam bit ALIGNED = ((SPARE_BASE % SPAN) == 0);

   generate
      if (ALIGNED) begin : g_or_map
         assign addr = ADDR_W'(SPARE_BASE) | ADDR_W'({idx, pos});
      end else begin : g_add_map
         assign addr = ADDR_W'(SPARE_BASE)
                     + (ADDR_W'(idx) << BUF_LG2)
                     + ADDR_W'(pos);
      end
   endgenerate

   // R3
   addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((addr >= ADDR_W'(SPARE_BASE)) &&
                 (addr <  ADDR_W'(SPARE_BASE + SPAN))));

endmodule

// File: rtl/spare_addr_mapper.sv
module spare_addr_mapper #(
   parameter int PAGE_W      = 13,
   parameter int SPARE_W     = 8,
   parameter int OFF_W       = 8,
   parameter int LEN_W       = 9,
   parameter int NUM_BUFS    = 8,
   parameter int BUF_BYTES   = 64,
   parameter int CHUNK_BYTES = 512,
   parameter int ADDR_W      = 13,
   parameter int SPARE_BASE  = 'h1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [PAGE_W-1:0]  cfg_page_size,
   input  logic [SPARE_W-1:0] cfg_spare_size,
   output logic               cfg_ready,
   input  logic               xfer_valid,
   input  logic [OFF_W-1:0]   xfer_offset,
   input  logic [LEN_W-1:0]   xfer_len,
   output logic               xfer_ready,
   output logic               ram_addr_valid,
   output logic [ADDR_W-1:0]  ram_addr,
   output logic               xfer_done,
   output logic               xfer_err
);

   localparam int IDX_W     = $clog2(NUM_BUFS);
   localparam int BUF_LG2   = $clog2(BUF_BYTES);
   localparam int CHUNK_LG2 = $clog2(CHUNK_BYTES);

   initial begin
      buf_pow2_chk: assert ((1 << BUF_LG2) == BUF_BYTES)
         else $error("BUF_BYTES must be a power of two");
      chunk_pow2_chk: assert ((1 << CHUNK_LG2) == CHUNK_BYTES)
         else $error("CHUNK_BYTES must be a power of two");
      bufs_chk: assert (NUM_BUFS >= 2 && (1 << IDX_W) == NUM_BUFS)
         else $error("NUM_BUFS must be a power of two of at least 2");
      addr_w_chk: assert (ADDR_W >= IDX_W + BUF_LG2 &&
                          (SPARE_BASE + NUM_BUFS * BUF_BYTES) <= (1 << ADDR_W))
         else $error("ADDR_W too narrow for the spare window");
      page_w_chk: assert (PAGE_W > CHUNK_LG2 && SPARE_W >= 2)
         else $error("PAGE_W or SPARE_W too narrow");
   end

   logic                 walk_idle;
   logic                 load_go;
   logic                 start_go;
   logic [SPARE_W-1:0]   per_buf;
   logic [IDX_W-1:0]     cur_idx;
   logic [BUF_LG2-1:0]   cur_pos;

   assign load_go    = cfg_load && walk_idle;
   assign xfer_ready = walk_idle && cfg_ready && !cfg_load;
   assign start_go   = xfer_valid && xfer_ready;

   spare_size_div #(
      .PAGE_W    (PAGE_W),
      .SPARE_W   (SPARE_W),
      .CHUNK_LG2 (CHUNK_LG2)
   ) i_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_go),
      .page_size  (cfg_page_size),
      .spare_size (cfg_spare_size),
      .ready      (cfg_ready),
      .per_buf    (per_buf)
   );

   spare_walk #(
      .OFF_W     (OFF_W),
      .LEN_W     (LEN_W),
      .SPARE_W   (SPARE_W),
      .NUM_BUFS  (NUM_BUFS),
      .BUF_BYTES (BUF_BYTES)
   ) i_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_go),
      .offset     (xfer_offset),
      .len        (xfer_len),
      .per_buf    (per_buf),
      .idle       (walk_idle),
      .idx        (cur_idx),
      .pos        (cur_pos),
      .addr_valid (ram_addr_valid),
      .done       (xfer_done),
      .err        (xfer_err)
   );

   spare_addr_form #(
      .IDX_W      (IDX_W),
      .BUF_LG2    (BUF_LG2),
      .ADDR_W     (ADDR_W),
      .SPARE_BASE (SPARE_BASE)
   ) i_form (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (ram_addr_valid),
      .idx   (cur_idx),
      .pos   (cur_pos),
      .addr  (ram_addr)
   );

   // R9
   ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_addr_valid || xfer_done) |-> !xfer_ready);

   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_addr_valid && $past(ram_addr_valid)) |->
         ((ram_addr == $past(ram_addr) + ADDR_W'(1)) ||
          (ram_addr[BUF_LG2-1:0] == '0)));

endmodule

// File: tb/test_spare_addr_mapper.sv
module test_spare_addr_mapper;

   localparam int PAGE_W  = 13;
   localparam int SPARE_W = 8;
   localparam int OFF_W   = 8;
   localparam int LEN_W   = 9;
   localparam int ADDR_W  = 13;
   localparam int NVEC    = 9;
   localparam int VEC_W   = PAGE_W + SPARE_W + OFF_W + LEN_W;

   // {page, spare, offset, length}
   localparam logic [VEC_W-1:0] VEC [NVEC] = '{
      {13'd2048, 8'd64,  8'd0,   9'd20},
      {13'd2048, 8'd64,  8'd14,  9'd4},
      {13'd512,  8'd16,  8'd5,   9'd8},
      {13'd4096, 8'd218, 8'd20,  9'd12},
      {13'd4096, 8'd218, 8'd175, 9'd30},
      {13'd4096, 8'd128, 8'd100, 9'd30},
      {13'd512,  8'd16,  8'd170, 9'd10},
      {13'd2048, 8'd64,  8'd30,  9'd0},
      {13'd4096, 8'd218, 8'd250, 9'd3}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_load = 1'b0;
   logic [PAGE_W-1:0]  cfg_page_size = '0;
   logic [SPARE_W-1:0] cfg_spare_size = '0;
   logic               cfg_ready;
   logic               xfer_valid = 1'b0;
   logic [OFF_W-1:0]   xfer_offset = '0;
   logic [LEN_W-1:0]   xfer_len = '0;
   logic               xfer_ready;
   logic               ram_addr_valid;
   logic [ADDR_W-1:0]  ram_addr;
   logic               xfer_done;
   logic               xfer_err;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   spare_addr_mapper i_spare_addr_mapper (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_load       (cfg_load),
      .cfg_page_size  (cfg_page_size),
      .cfg_spare_size (cfg_spare_size),
      .cfg_ready      (cfg_ready),
      .xfer_valid     (xfer_valid),
      .xfer_offset    (xfer_offset),
      .xfer_len       (xfer_len),
      .xfer_ready     (xfer_ready),
      .ram_addr_valid (ram_addr_valid),
      .ram_addr       (ram_addr),
      .xfer_done      (xfer_done),
      .xfer_err       (xfer_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int share_of(input int page, input int spare);
      int chunks;
      chunks = page / 512;
      if (chunks == 0) chunks = 1;
      return (spare / chunks) & ~1;
   endfunction

   function automatic void model(input int off, input int i, input int sb,
                                 output int addr, output int idx, output int r);
      int lin;
      lin = off + i;
      idx = (sb == 0) ? 7 : lin / sb;
      if (idx > 7) idx = 7;
      r    = lin - idx * sb;
      addr = 'h1000 + idx * 'h40 + r;
   endfunction

   task automatic load_cfg(input int page, input int spare);
      int n;
      @(negedge clk);
      cfg_load       = 1'b1;
      cfg_page_size  = PAGE_W'(page);
      cfg_spare_size = SPARE_W'(spare);
      @(negedge clk);
      cfg_load = 1'b0;
      n = 1;
      chk(cfg_ready == 1'b0, "R2 cfg_ready low after load", int'(cfg_ready), 0);
      while (!cfg_ready && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk(n == SPARE_W + 1, "R2 configuration latency", n, SPARE_W + 1);
   endtask

   task automatic run_xfer(input int off, input int len, input int sb, input bit hold);
      int n, cnt, k, exp_cnt, addr, idx, r;
      bit exp_err, got_done;
      string tag;
      k = (sb == 0) ? 7 : off / sb;
      if (k > 7) k = 7;
      exp_cnt = len;
      exp_err = 1'b0;
      for (int i = 0; i < len; i++) begin
         model(off, i, sb, addr, idx, r);
         if (r >= 64) begin
            exp_cnt = i;
            exp_err = 1'b1;
            break;
         end
      end
      chk(xfer_ready == 1'b1, "R9 ready before request", int'(xfer_ready), 1);
      xfer_valid  = 1'b1;
      xfer_offset = OFF_W'(off);
      xfer_len    = LEN_W'(len);
      @(negedge clk);
      n = 1;
      if (hold) begin
         xfer_offset = OFF_W'(off ^ 'h55);
         xfer_len    = LEN_W'(3);
      end else begin
         xfer_valid = 1'b0;
      end
      cnt = 0;
      got_done = 1'b0;
      for (int g = 0; g < 700 && !got_done; g++) begin
         if (ram_addr_valid) begin
            model(off, cnt, sb, addr, idx, r);
            if (cnt == 0) tag = "R3 first address";
            else if (r == 0 && idx > 0 && idx < 7) tag = "R5 buffer hand-over";
            else if (idx == 7) tag = "R6 last buffer";
            else tag = "R4 address";
            chk(int'(ram_addr) == addr, tag, int'(ram_addr), addr);
            chk(n == k + 2 + cnt, "R8 address cycle", n, k + 2 + cnt);
            chk(xfer_ready == 1'b0, "R9 ready low while streaming", int'(xfer_ready), 0);
            cnt++;
         end
         if (xfer_done) begin
            got_done = 1'b1;
            chk(n == k + 2 + exp_cnt + (exp_err ? 1 : 0), "R8 done cycle",
                n, k + 2 + exp_cnt + (exp_err ? 1 : 0));
            chk(int'(xfer_err) == int'(exp_err), "R7 error flag", int'(xfer_err), int'(exp_err));
            chk(cnt == exp_cnt, "R7 issued byte count", cnt, exp_cnt);
         end else begin
            chk(xfer_err == 1'b0, "R10 err without done", int'(xfer_err), 0);
            @(negedge clk);
            n++;
         end
      end
      xfer_valid = 1'b0;
      if (!got_done) chk(1'b0, "R8 done never seen", 0, 1);
      @(negedge clk);
      chk(xfer_done == 1'b0, "R10 done single cycle", int'(xfer_done), 0);
      chk(ram_addr_valid == 1'b0, "R9 no restart from held request", int'(ram_addr_valid), 0);
      chk(xfer_ready == 1'b1, "R9 ready after done", int'(xfer_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int page, spare, off, len, sb;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk(cfg_ready == 1'b0 && xfer_ready == 1'b0, "R1 ready during reset",
          int'({cfg_ready, xfer_ready}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cfg_ready == 1'b0, "R1 cfg_ready after reset", int'(cfg_ready), 0);
      chk(xfer_ready == 1'b0, "R1 xfer_ready after reset", int'(xfer_ready), 0);
      chk({ram_addr_valid, xfer_done, xfer_err} == 3'b000, "R1 outputs idle after reset",
          int'({ram_addr_valid, xfer_done, xfer_err}), 0);

      // R9: request before any configuration is ignored
      xfer_valid = 1'b1;
      xfer_len   = LEN_W'(4);
      repeat (3) @(negedge clk);
      chk(ram_addr_valid == 1'b0 && xfer_done == 1'b0, "R9 unconfigured request ignored",
          int'({ram_addr_valid, xfer_done}), 0);
      xfer_valid = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         {page, spare, off, len} = {19'd0, VEC[v][VEC_W-1 -: PAGE_W],
                                    24'd0, VEC[v][OFF_W+LEN_W+SPARE_W-1 -: SPARE_W],
                                    24'd0, VEC[v][OFF_W+LEN_W-1 -: OFF_W],
                                    23'd0, VEC[v][LEN_W-1:0]};
         load_cfg(page, spare);
         sb = share_of(page, spare);
         run_xfer(off, len, sb, 1'b0);
      end

      // R9: request held high with altered fields during a transfer
      load_cfg(4096, 218);
      run_xfer(20, 12, share_of(4096, 218), 1'b1);

      // R6: 218-byte spare, tail of the area lands in buffer 7
      run_xfer(200, 18, share_of(4096, 218), 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule